// File: doc/BRIEF.md
# Sensor code calibration and conversion unit

This unit maps between raw ADC codes from one temperature sensor and temperatures, using a straight-line model. The model has a scaled slope and an offset. A calibration request supplies two codes: one read at 30 °C and one read at 120 °C. From these the unit builds the slope and offset. A single-point calibration keeps a default slope and uses only the 30 °C code. After calibration, a forward request turns a code into whole degrees, rounded symmetrically and reported in millidegrees. A reverse request turns a temperature in degrees into a code, clamped to a programmable window, which is suitable for a threshold register.

A forward request may also select a direct mode. In that mode the code is taken as a signed deci-degree field and scaled to millidegrees without the model. All divisions go through one shared restoring divider. Each operation therefore takes tens of cycles. It raises `busy` and ends with a one-cycle `done`, which is presented together with its result. A calibration that produces a zero slope sets an error flag. That flag blocks both conversions until a later calibration yields a usable slope.

Top module: `tcal_conv_unit`

## Requirements
- R1: A two-point calibration sets `slope_out` to ((hi − lo) × SCALE) / 90, truncated toward zero. Here lo is `cal_code_lo` (30 °C) and hi is `cal_code_hi` (120 °C), both taken as unsigned.
- R2: A single-point calibration (`cal_two_pt` = 0) sets `slope_out` to the DEF_SLOPE parameter.
- R3: Every calibration sets `offset_out` to lo × SCALE − 30 × slope, using the new slope.
- R4: A forward conversion with `c2t_deci` = 0 first forms n = code × SCALE − offset. It then adds slope/2 to n when n > 0 and subtracts slope/2 when n < 0 (both divisions truncate toward zero). It divides the result by slope with truncation toward zero. `temp_mc` is the quotient × 1000.
- R5: A forward conversion with `c2t_deci` = 1 sets `temp_mc` to the `code_in` field read as a two's-complement CW-bit value, multiplied by 100.
- R6: A reverse conversion sets `code_out` to (`degc_in` × slope + offset) / SCALE, truncated toward zero and then clamped to [CODE_MIN, CODE_MAX].
- R7: An accepted request raises `busy` from the next cycle until its `done` cycle, inclusive. `done` lasts exactly one cycle, and the new result is visible in that cycle. Results change only while `busy` is high. Requests that arrive while `busy` is high are dropped.
- R8: When several requests arrive in the same idle cycle, only one is accepted. Calibration is chosen first, then the forward conversion, then the reverse conversion. The others are discarded.
- R9: A calibration that gives slope 0 sets `cal_err`. While `cal_err` is high, conversion requests are refused: `busy` stays low, no `done` follows and results hold. A calibration with a nonzero slope clears `cal_err`.
- R10: After reset the outputs are: `slope_out` = DEF_SLOPE, `offset_out` = 0, `temp_mc` = 0, `code_out` = CODE_MIN, and `cal_err`, `busy` and `done` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_req | input | 1 | Start a calibration |
| cal_two_pt | input | 1 | 1: two-point slope, 0: default slope |
| cal_code_lo | input | CW | Code read at 30 °C |
| cal_code_hi | input | CW | Code read at 120 °C |
| c2t_req | input | 1 | Start a code-to-temperature conversion |
| c2t_deci | input | 1 | Treat `code_in` as signed deci-degrees |
| code_in | input | CW | Code to convert |
| t2c_req | input | 1 | Start a temperature-to-code conversion |
| degc_in | input | TW | Signed temperature in whole degrees |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| temp_mc | output | 32 | Signed millidegree result |
| code_out | output | CW | Clamped code result |
| slope_out | output | 32 | Current signed scaled slope |
| offset_out | output | 32 | Current signed scaled offset |
| cal_err | output | 1 | Zero-slope calibration flag |

## Verification
A calibration request and a conversion request can arrive in the same idle cycle. The bench provokes this by raising `cal_req` and `c2t_req` on the same edge. It then judges the outcome from the ports. The slope and offset must take the new calibration values, `temp_mc` must keep its earlier value, and exactly one `done` may appear within a long window. A second overlap occurs when a request lands during an operation that is already in progress. The bench raises `t2c_req` while a forward conversion is running. It expects `code_out` to remain unchanged and no extra `done` to appear.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
  localparam int TCAL_W     = 32;
  localparam int TCAL_PT_LO = 30;
  localparam int TCAL_PT_HI = 120;

  typedef logic signed [TCAL_W-1:0] tcal_word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_SET,
    ST_CAL_DIV,
    ST_CAL_FIN,
    ST_C2T_DIV,
    ST_C2T_DECI,
    ST_T2C_DIV,
    ST_DONE
  } tcal_state_e;

  // Symmetric rounding bias: push the numerator away from zero by half a slope.
  function automatic tcal_word_t tcal_bias(tcal_word_t num, tcal_word_t slope);
    tcal_word_t half;
    half = slope / tcal_word_t'(2);
    if (num > 0)      return num + half;
    else if (num < 0) return num - half;
    else              return '0;
  endfunction

  function automatic tcal_word_t tcal_clamp(tcal_word_t v, tcal_word_t lo, tcal_word_t hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction
endpackage

// File: rtl/tcal_rdiv.sv
module tcal_rdiv #(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [DW-1:0] num,
  input  logic signed [DW-1:0] den,
  output logic                 run,
  output logic                 valid,
  output logic signed [DW-1:0] quot
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   q;
  logic [DW-1:0]   rem;
  logic [DW-1:0]   dmag;
  logic            neg;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   nmag_in;
  logic [DW-1:0]   dmag_in;
  logic [DW:0]     shifted;
  logic [DW:0]     trial;

  assign nmag_in = num[DW-1] ? $unsigned(-num) : $unsigned(num);
  assign dmag_in = den[DW-1] ? $unsigned(-den) : $unsigned(den);
  assign shifted = {rem, q[DW-1]};
  assign trial   = shifted - {1'b0, dmag};
  assign quot    = neg ? -$signed(q) : $signed(q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0; rem <= '0; dmag <= '0; neg <= 1'b0;
      cnt <= '0; run <= 1'b0; valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start) begin
        q    <= nmag_in;
        dmag <= dmag_in;
        rem  <= '0;
        neg  <= num[DW-1] ^ den[DW-1];
        cnt  <= CNTW'(DW);
        run  <= 1'b1;
      end else if (run) begin
        if (!trial[DW]) begin
          rem <= trial[DW-1:0];
          q   <= {q[DW-2:0], 1'b1};
        end else begin
          rem <= shifted[DW-1:0];
          q   <= {q[DW-2:0], 1'b0};
        end
        cnt <= cnt - CNTW'(1);
        if (cnt == CNTW'(1)) begin
          run   <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  // R7: the divider reports completion for a single cycle only
  assert_div_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R7: a new division never starts over one in flight
  assert_div_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run);
endmodule

// File: rtl/tcal_deci.sv
module tcal_deci import tcal_pkg::*; #(
  parameter int CW = 10
) (
  input  logic [CW-1:0] field,
  output tcal_word_t    mc
);
  localparam tcal_word_t HUNDRED = tcal_word_t'(100);
  tcal_word_t sext;

  assign sext = {{(TCAL_W-CW){field[CW-1]}}, field};
  assign mc   = sext * HUNDRED;
endmodule

// File: rtl/tcal_conv_unit.sv
module tcal_conv_unit import tcal_pkg::*; #(
  parameter int CW        = 10,
  parameter int TW        = 16,
  parameter int SCALE     = 1000,
  parameter int DEF_SLOPE = 3200,
  parameter int CODE_MIN  = 5,
  parameter int CODE_MAX  = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_req,
  input  logic                 cal_two_pt,
  input  logic [CW-1:0]        cal_code_lo,
  input  logic [CW-1:0]        cal_code_hi,
  input  logic                 c2t_req,
  input  logic                 c2t_deci,
  input  logic [CW-1:0]        code_in,
  input  logic                 t2c_req,
  input  logic signed [TW-1:0] degc_in,
  output logic                 busy,
  output logic                 done,
  output logic signed [31:0]   temp_mc,
  output logic [CW-1:0]        code_out,
  output logic signed [31:0]   slope_out,
  output logic signed [31:0]   offset_out,
  output logic                 cal_err
);
  localparam tcal_word_t SCALE_W = tcal_word_t'(SCALE);
  localparam tcal_word_t DEF_W   = tcal_word_t'(DEF_SLOPE);
  localparam tcal_word_t LO_W    = tcal_word_t'(CODE_MIN);
  localparam tcal_word_t HI_W    = tcal_word_t'(CODE_MAX);
  localparam tcal_word_t PTLO_W  = tcal_word_t'(TCAL_PT_LO);
  localparam tcal_word_t SPAN_W  = tcal_word_t'(TCAL_PT_HI - TCAL_PT_LO);
  localparam tcal_word_t MILLI_W = tcal_word_t'(1000);

  tcal_state_e   st;
  tcal_word_t    slope_q, offset_q, temp_q;
  logic [CW-1:0] code_q, c1_lat, code_lat;
  logic          err_q;

  // Named events for assertions and readability
  logic acc_cal, acc_c2t, acc_t2c, idle;
  logic div_start, div_run, div_valid;
  tcal_word_t div_num, div_den, div_quot, clamp_v, deci_mc;
  tcal_word_t lo_s, hi_s, cin_s, c1_s, deg_s;

  assign idle    = (st == ST_IDLE);
  assign acc_cal = idle && cal_req;
  assign acc_c2t = idle && !cal_req && c2t_req && !err_q;
  assign acc_t2c = idle && !cal_req && !c2t_req && t2c_req && !err_q;

  assign lo_s  = tcal_word_t'(cal_code_lo);
  assign hi_s  = tcal_word_t'(cal_code_hi);
  assign cin_s = tcal_word_t'(code_in);
  assign c1_s  = tcal_word_t'(c1_lat);
  assign deg_s = {{(TCAL_W-TW){degc_in[TW-1]}}, degc_in};

  always_comb begin
    div_num = '0;
    div_den = SCALE_W;
    if (acc_cal) begin
      div_num = (hi_s - lo_s) * SCALE_W;
      div_den = SPAN_W;
    end else if (acc_c2t) begin
      div_num = tcal_bias(cin_s * SCALE_W - offset_q, slope_q);
      div_den = slope_q;
    end else if (acc_t2c) begin
      div_num = deg_s * slope_q + offset_q;
      div_den = SCALE_W;
    end
  end

  assign div_start = (acc_cal && cal_two_pt) || (acc_c2t && !c2t_deci) || acc_t2c;
  assign clamp_v   = tcal_clamp(div_quot, LO_W, HI_W);

  tcal_rdiv #(.DW(TCAL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(div_num), .den(div_den),
    .run(div_run), .valid(div_valid), .quot(div_quot)
  );

  tcal_deci #(.CW(CW)) u_deci (
    .field(code_lat), .mc(deci_mc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      slope_q  <= DEF_W;
      offset_q <= '0;
      temp_q   <= '0;
      code_q   <= LO_W[CW-1:0];
      err_q    <= 1'b0;
      c1_lat   <= '0;
      code_lat <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (acc_cal) begin
            c1_lat <= cal_code_lo;
            st     <= cal_two_pt ? ST_CAL_DIV : ST_CAL_SET;
          end else if (acc_c2t) begin
            code_lat <= code_in;
            st       <= c2t_deci ? ST_C2T_DECI : ST_C2T_DIV;
          end else if (acc_t2c) begin
            st <= ST_T2C_DIV;
          end
        end
        ST_CAL_SET: begin
          slope_q <= DEF_W;
          st      <= ST_CAL_FIN;
        end
        ST_CAL_DIV: if (div_valid) begin
          slope_q <= div_quot;
          st      <= ST_CAL_FIN;
        end
        ST_CAL_FIN: begin
          offset_q <= c1_s * SCALE_W - PTLO_W * slope_q;
          err_q    <= (slope_q == '0);
          st       <= ST_DONE;
        end
        ST_C2T_DECI: begin
          temp_q <= deci_mc;
          st     <= ST_DONE;
        end
        ST_C2T_DIV: if (div_valid) begin
          temp_q <= div_quot * MILLI_W;
          st     <= ST_DONE;
        end
        ST_T2C_DIV: if (div_valid) begin
          code_q <= clamp_v[CW-1:0];
          st     <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = !idle;
  assign done       = (st == ST_DONE);
  assign temp_mc    = temp_q;
  assign code_out   = code_q;
  assign slope_out  = slope_q;
  assign offset_out = offset_q;
  assign cal_err    = err_q;

  // R7: completion strobe lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: results only move while an operation is in flight
  assert_results_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(slope_q) && $stable(offset_q) && $stable(temp_q) && $stable(code_q)));
  // R6: the reverse result never leaves the clamp window
  assert_code_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(code_out) >= CODE_MIN) && (int'(code_out) <= CODE_MAX));
  // R9: a conversion request under the error flag is refused
  assert_refuse_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cal_err && !cal_req && (c2t_req || t2c_req)) |=> !busy);
  // R9: the error flag follows the slope value
  assert_err_rise_zero_slope_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_err) |-> (slope_q == '0));
  assert_err_fall_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_err) |-> (slope_q != '0));
  // R8: simultaneous calibration and conversion requests pick calibration
  assert_cal_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cal_req && (c2t_req || t2c_req)) |=> (st == ST_CAL_DIV || st == ST_CAL_SET));
endmodule

// File: tb/tb_tcal_conv_unit.sv
module tb_tcal_conv_unit;
  localparam int CW = 10, TW = 16, SCALE = 1000, DEF_SLOPE = 3200;
  localparam int CODE_MIN = 5, CODE_MAX = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cal_req = 0, cal_two_pt = 0, c2t_req = 0, c2t_deci = 0, t2c_req = 0;
  logic [CW-1:0] cal_code_lo = '0, cal_code_hi = '0, code_in = '0;
  logic signed [TW-1:0] degc_in = '0;
  logic busy, done, cal_err;
  logic signed [31:0] temp_mc, slope_out, offset_out;
  logic [CW-1:0] code_out;

  int checks = 0, errors = 0;
  longint m_slope = DEF_SLOPE, m_off = 0;

  always #10 clk = ~clk;

  tcal_conv_unit #(.CW(CW), .TW(TW), .SCALE(SCALE), .DEF_SLOPE(DEF_SLOPE),
                   .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_two_pt(cal_two_pt),
    .cal_code_lo(cal_code_lo), .cal_code_hi(cal_code_hi), .c2t_req(c2t_req),
    .c2t_deci(c2t_deci), .code_in(code_in), .t2c_req(t2c_req), .degc_in(degc_in),
    .busy(busy), .done(done), .temp_mc(temp_mc), .code_out(code_out),
    .slope_out(slope_out), .offset_out(offset_out), .cal_err(cal_err));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_c2t(longint code);
    longint n = code * SCALE - m_off;
    longint h = m_slope / 2;
    if (n > 0) n = n + h; else if (n < 0) n = n - h;
    return (n / m_slope) * 1000;
  endfunction

  function automatic longint exp_t2c(longint deg);
    longint v = (deg * m_slope + m_off) / SCALE;
    if (v < CODE_MIN) v = CODE_MIN;
    if (v > CODE_MAX) v = CODE_MAX;
    return v;
  endfunction

  // Release requests one cycle after raising them, then wait for done.
  task automatic finish_op(input string req);
    int tmo = 0;
    @(negedge clk);
    cal_req = 0; c2t_req = 0; t2c_req = 0;
    check(busy === 1'b1, "R7", "busy after accept", longint'(busy), 1);
    while (done !== 1'b1 && tmo < 200) begin @(negedge clk); tmo++; end
    check(done === 1'b1, req, "done seen", longint'(done), 1);
  endtask

  task automatic do_cal(input bit two, input int lo, input int hi, input string req);
    @(negedge clk);
    cal_two_pt = two; cal_code_lo = CW'(lo); cal_code_hi = CW'(hi); cal_req = 1;
    finish_op(req);
    m_slope = two ? ((longint'(hi) - lo) * SCALE) / 90 : DEF_SLOPE;
    m_off   = longint'(lo) * SCALE - 30 * m_slope;
    check(slope_out == m_slope, req, "slope", slope_out, m_slope);
    check(offset_out == m_off, "R3", "offset", offset_out, m_off);
    check(cal_err == (m_slope == 0), "R9", "err flag", longint'(cal_err), longint'(m_slope == 0));
  endtask

  task automatic do_c2t(input int code);
    longint e;
    @(negedge clk);
    c2t_deci = 0; code_in = CW'(code); c2t_req = 1;
    finish_op("R4");
    e = exp_c2t(code);
    check(temp_mc == e, "R4", $sformatf("c2t code %0d", code), temp_mc, e);
  endtask

  task automatic do_deci(input int code);
    longint e = ((code >= (1 << (CW-1))) ? code - (1 << CW) : code) * 100;
    @(negedge clk);
    c2t_deci = 1; code_in = CW'(code); c2t_req = 1;
    finish_op("R5");
    c2t_deci = 0;
    check(temp_mc == e, "R5", $sformatf("deci code %0d", code), temp_mc, e);
  endtask

  task automatic do_t2c(input int deg);
    longint e;
    @(negedge clk);
    degc_in = TW'(deg); t2c_req = 1;
    finish_op("R6");
    e = exp_t2c(deg);
    check(code_out == e, "R6", $sformatf("t2c deg %0d", deg), code_out, e);
  endtask

  task automatic sweep();
    for (int c = 0; c < (1 << CW); c += 4) do_c2t(c);
    for (int d = -60; d <= 140; d += 2) do_t2c(d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint hold_t, hold_c;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(slope_out == DEF_SLOPE, "R10", "reset slope", slope_out, DEF_SLOPE);
    check(offset_out == 0, "R10", "reset offset", offset_out, 0);
    check(temp_mc == 0, "R10", "reset temp", temp_mc, 0);
    check(code_out == CODE_MIN, "R10", "reset code", code_out, CODE_MIN);
    check(!cal_err && !busy && !done, "R10", "reset flags",
          longint'({cal_err, busy, done}), 0);

    do_cal(1, 300, 700, "R1");
    sweep();
    for (int c = 0; c < (1 << CW); c++) do_deci(c);
    do_cal(1, 800, 200, "R1");
    sweep();
    do_cal(0, 500, 0, "R2");
    sweep();
    @(negedge clk);
    check(!busy, "R7", "idle after done", longint'(busy), 0);

    // R8: calibration and forward conversion in the same cycle
    hold_t = temp_mc;
    @(negedge clk);
    cal_two_pt = 0; cal_code_lo = CW'(100); cal_req = 1; code_in = CW'(900); c2t_req = 1;
    finish_op("R8");
    check(slope_out == DEF_SLOPE, "R8", "slope from cal", slope_out, DEF_SLOPE);
    check(offset_out == 100 * SCALE - 30 * DEF_SLOPE, "R8", "offset from cal",
          offset_out, 100 * SCALE - 30 * DEF_SLOPE);
    check(temp_mc == hold_t, "R8", "temp untouched", temp_mc, hold_t);
    m_slope = DEF_SLOPE; m_off = 100 * SCALE - 30 * DEF_SLOPE;
    seen = 0;
    repeat (60) begin @(negedge clk); if (done) seen++; end
    check(seen == 0, "R8", "no second done", seen, 0);

    // R7: request during an operation is dropped
    do_t2c(20);
    hold_c = code_out;
    @(negedge clk);
    c2t_deci = 0; code_in = CW'(600); c2t_req = 1;
    @(negedge clk);
    c2t_req = 0; degc_in = TW'(-50); t2c_req = 1;
    @(negedge clk);
    t2c_req = 0;
    while (!done) @(negedge clk);
    check(temp_mc == exp_c2t(600), "R7", "running op result", temp_mc, exp_c2t(600));
    seen = 0;
    repeat (60) begin @(negedge clk); if (done) seen++; end
    check(seen == 0, "R7", "dropped request no done", seen, 0);
    check(code_out == hold_c, "R7", "dropped request code", code_out, hold_c);

    // R9: zero slope blocks conversions
    do_cal(1, 400, 400, "R9");
    hold_t = temp_mc; hold_c = code_out;
    @(negedge clk);
    code_in = CW'(10); c2t_req = 1; degc_in = TW'(100); t2c_req = 1;
    @(negedge clk);
    c2t_req = 0;
    check(!busy, "R9", "c2t refused busy", longint'(busy), 0);
    @(negedge clk);
    t2c_req = 0;
    check(!busy, "R9", "t2c refused busy", longint'(busy), 0);
    seen = 0;
    repeat (50) begin @(negedge clk); if (done || busy) seen++; end
    check(seen == 0, "R9", "no activity while err", seen, 0);
    check(temp_mc == hold_t, "R9", "temp held", temp_mc, hold_t);
    check(code_out == hold_c, "R9", "code held", code_out, hold_c);
    do_cal(0, 500, 0, "R2");
    do_c2t(700);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule